// File: doc/BRIEF.md
# Split-transfer shift-clock pulse inserter

This block adds a single extra pulse to a video memory's shift clock while the display is blanked, giving the memory the clock edge it needs to complete a split shift-register transfer. The trigger is a rising edge on an asynchronous transfer flag. It takes effect only while an enable bit is set and blank is active. The block merges the extra pulse into the normal shift-clock stream by OR. The normal stream is expected to be idle during blank, so the two do not collide.

The flag passes through a two-flop synchronizer and then an edge detector. A qualified edge starts a pulse one clock after detection. The pulse stays high for a whole number of clock cycles, taken as the smallest count that covers the minimum high time (`MIN_HIGH_PS` divided by `CLK_PERIOD_PS`, rounded up). With the defaults of a 10 ns clock and a 15 ns minimum, the pulse is two cycles wide. It starts on the second clock edge after the edge that first samples the flag high, which keeps the start within a 20 ns budget at the default period. Reset is asserted asynchronously, active low, and released synchronously inside the block.

Top module: `sclk_split_inserter`

## Requirements
- R1: While reset is asserted, and after its release until a qualified flag edge, `sclk_o` equals `sclk_i` and the inserted pulse is low, whatever the flag does.
- R2: Whenever no inserted pulse is active, `sclk_o` follows `sclk_i` combinationally.
- R3: A qualified flag rising edge produces exactly one inserted pulse, held high for HIGH_CYC = ceil(MIN_HIGH_PS / CLK_PERIOD_PS) consecutive cycles (2 with defaults).
- R4: If clock edge k is the first to sample the flag high, `sclk_o` is high through the inserted pulse from edge k+2. The pulse starts one cycle after the synchronized edge is detected.
- R5: A flag edge detected while `xfer_en_i` is 0 produces no pulse.
- R6: A flag edge detected while `blank_i` is 0 produces no pulse.
- R7: A flag held high for many cycles yields only one pulse. A high level alone never triggers.
- R8: A flag edge detected while an inserted pulse is active is ignored. It neither extends the pulse nor queues a second one. A later edge, detected once the pulse has ended, triggers normally.
- R9: A flag high for a single clock cycle is still detected through the two-flop synchronizer. `xfer_en_i` and `blank_i` are evaluated in the cycle in which the edge is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xfer_en_i | input | 1 | Enables split-transfer pulse insertion when 1 |
| flag_i | input | 1 | Asynchronous transfer request flag; its rising edge triggers |
| blank_i | input | 1 | Display blank, active high |
| sclk_i | input | 1 | Normal shift clock stream |
| sclk_o | output | 1 | Shift clock with the inserted pulse merged in |

## Verification
The bench watches for four failures. A held flag that re-fires every cycle would make the pulse far too long. Edges that arrive during a pulse but are not ignored would stretch the pulse past two cycles. Qualification against blank or enable taken in the wrong cycle would let pulses leak outside blanking. A latency error would move the first high cycle away from the third clock after the flag is driven. A behavioural model compares `sclk_o` on every clock, with the normal shift clock both running and idle. Pulse-width and start-cycle counts catch any stretch or slip.

// File: rtl/xfer_sclk_pkg.sv
package xfer_sclk_pkg;

  // State of the inserted-pulse generator
  typedef enum logic {
    PULSE_IDLE   = 1'b0,
    PULSE_ACTIVE = 1'b1
  } pulse_state_e;

  // Integer ceiling division for deriving cycle counts from picoseconds
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sclk_rst_sync.sv
module sclk_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_sync_no = rst_q[1];

endmodule

// File: rtl/sclk_flag_edge.sv
module sclk_flag_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  // Next-state: shift the asynchronous flag through the synchronizer chain
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], flag_i};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // Rising edge of the synchronized flag, one cycle wide
  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R7: a detected edge never lasts two cycles, so a held level cannot re-fire
  a_r7_single_cycle_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sclk_pulse_timer.sv
module sclk_pulse_timer
  import xfer_sclk_pkg::*;
#(
  parameter int HIGH_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic en_i,
  input  logic blank_i,
  output logic pulse_o
);

  localparam int             CW   = (HIGH_CYC > 1) ? $clog2(HIGH_CYC) : 1;
  localparam logic [CW-1:0]  LOAD = CW'(HIGH_CYC - 1);

  pulse_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          accept;

  // Next-state logic
  always_comb begin
    accept  = trig_i & en_i & blank_i & (state_q == PULSE_IDLE);
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      PULSE_IDLE: begin
        if (accept) begin
          state_d = PULSE_ACTIVE;
          cnt_d   = LOAD;
          cnt_en  = 1'b1;
        end
      end
      PULSE_ACTIVE: begin
        if (cnt_q == '0) begin
          state_d = PULSE_IDLE;
        end else begin
          cnt_d  = cnt_q - CW'(1);
          cnt_en = 1'b1;
        end
      end
    endcase
  end

  // State and counter registers with explicit enable on the counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PULSE_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  // Decode of a single state flop: glitch-free pulse output
  assign pulse_o = (state_q == PULSE_ACTIVE);

  // Checker: length of the current high run
  logic [CW:0] run_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len_q <= '0;
    end else if (pulse_o) begin
      run_len_q <= run_len_q + (CW+1)'(1);
    end else begin
      run_len_q <= '0;
    end
  end

  // R3: every pulse ends after exactly HIGH_CYC cycles
  a_r3_exact_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> (run_len_q == (CW+1)'(HIGH_CYC)));

  // R8: an edge arriving during a pulse never extends it
  a_r8_no_extension: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len_q <= (CW+1)'(HIGH_CYC));

endmodule

// File: rtl/sclk_split_inserter.sv
module sclk_split_inserter
  import xfer_sclk_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int MIN_HIGH_PS   = 15000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xfer_en_i,
  input  logic flag_i,
  input  logic blank_i,
  input  logic sclk_i,
  output logic sclk_o
);

  localparam int HIGH_CYC = ceil_div(MIN_HIGH_PS, CLK_PERIOD_PS);

  logic rst_sync_n;
  logic flag_rise;
  logic xfer_pulse;

  sclk_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  sclk_flag_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_flag_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .flag_i (flag_i),
    .rise_o (flag_rise)
  );

  sclk_pulse_timer #(
    .HIGH_CYC (HIGH_CYC)
  ) u_pulse_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .trig_i  (flag_rise),
    .en_i    (xfer_en_i),
    .blank_i (blank_i),
    .pulse_o (xfer_pulse)
  );

  // Merge the inserted pulse into the normal shift-clock stream
  assign sclk_o = sclk_i | xfer_pulse;

  // R4: a pulse starts only on the cycle right after a detected edge
  a_r4_start_after_edge: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(xfer_pulse) |-> $past(flag_rise));

  // R5: a pulse starts only if enable was set when the edge was detected
  a_r5_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(xfer_pulse) |-> $past(xfer_en_i));

  // R6: a pulse starts only if blank was active when the edge was detected
  a_r6_needs_blank: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(xfer_pulse) |-> $past(blank_i));

  // R1: nothing is inserted while the internal reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_sync_n |-> !xfer_pulse);

endmodule

// File: tb/sclk_split_inserter_tb.sv
module sclk_split_inserter_tb;

  localparam int EXP_HIGH = 2;  // ceil(15 ns / 10 ns) at default parameters

  logic clk = 1'b0;
  logic rst_n, en, flag, blank, sclk;
  logic sclk_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  sclk_split_inserter u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .xfer_en_i (en),
    .flag_i    (flag),
    .blank_i   (blank),
    .sclk_i    (sclk),
    .sclk_o    (sclk_o)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference: flag history and a pulse countdown
  int   mcnt;
  logic f1, f2, f3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt = 0; f1 = 0; f2 = 0; f3 = 0;
    end else begin
      if (f2 && !f3 && en && blank && mcnt == 0) mcnt = EXP_HIGH;
      else if (mcnt > 0) mcnt--;
      f3 = f2; f2 = f1; f1 = flag;
    end
  end

  // Per-cycle comparison and pulse observation, away from the active edge
  int pulse_cycles;
  int first_cyc;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(cur_req, int'(sclk_o), int'(sclk | (mcnt > 0)), "sclk_o vs model");
      if (sclk_o && !sclk) begin
        pulse_cycles++;
        if (first_cyc < 0) first_cyc = cyc;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Drive one flag episode and report pulse cycles and start cycle
  task automatic flag_case(input string req, input logic e, input logic b,
                           input int hold, input int exp_cycles, input int exp_lat);
    int start;
    cur_req = req;
    en = e; blank = b; sclk = 1'b0;
    step(3);
    pulse_cycles = 0; first_cyc = -1;
    start = cyc;
    flag = 1'b1;
    step(hold);
    flag = 1'b0;
    step(10);
    chk(req, pulse_cycles, exp_cycles, "inserted high cycles");
    if (exp_lat > 0) chk(req, first_cyc - start, exp_lat, "start latency in cycles");
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; flag = 1'b0; blank = 1'b0; sclk = 1'b0;
    pulse_cycles = 0; first_cyc = -1;
    // R1: reset state, flag edges inside reset are not acted on
    step(2);
    en = 1'b1; blank = 1'b1; flag = 1'b1;
    step(2);
    chk("R1", int'(sclk_o), 0, "output low in reset");
    sclk = 1'b1; #1;
    chk("R1", int'(sclk_o), 1, "output follows sclk_i in reset");
    sclk = 1'b0; flag = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(6);
    chk("R1", int'(sclk_o), 0, "idle after reset release");

    // R2: pass-through of a running shift clock, no flag
    cur_req = "R2";
    blank = 1'b0;
    for (int i = 0; i < 12; i++) begin sclk = ~sclk; step(1); end
    sclk = 1'b0;

    // R3, R4, R9: single-cycle flag, enabled, in blank
    flag_case("R3", 1'b1, 1'b1, 1, EXP_HIGH, 3);
    flag_case("R9", 1'b1, 1'b1, 1, EXP_HIGH, 3);
    // R4: longer flag, same start cycle
    flag_case("R4", 1'b1, 1'b1, 3, EXP_HIGH, 3);
    // R5: disabled
    flag_case("R5", 1'b0, 1'b1, 2, 0, 0);
    // R6: outside blank
    flag_case("R6", 1'b1, 1'b0, 2, 0, 0);
    // R7: held level yields one pulse only
    flag_case("R7", 1'b1, 1'b1, 15, EXP_HIGH, 3);

    // R8: flag toggles so a second edge lands inside the pulse
    cur_req = "R8";
    en = 1'b1; blank = 1'b1;
    step(3);
    pulse_cycles = 0; first_cyc = -1;
    flag = 1'b1; step(1); flag = 1'b0; step(1); flag = 1'b1; step(1); flag = 1'b0;
    step(10);
    chk("R8", pulse_cycles, EXP_HIGH, "edge during pulse ignored");
    // R8: a later edge triggers again
    flag_case("R8", 1'b1, 1'b1, 1, EXP_HIGH, 3);

    // R9: enable rises only after the edge has been detected -> no pulse
    cur_req = "R9";
    en = 1'b0; blank = 1'b1;
    step(3);
    pulse_cycles = 0;
    flag = 1'b1; step(3); en = 1'b1; step(1); flag = 1'b0;
    step(8);
    chk("R9", pulse_cycles, 0, "gating taken at detection cycle");

    // R2: running shift clock during blank with a pulse merged in
    cur_req = "R2";
    blank = 1'b1; en = 1'b1;
    flag = 1'b1;
    for (int i = 0; i < 12; i++) begin sclk = ~sclk; step(1); end
    flag = 1'b0; sclk = 1'b0;
    step(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule